// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a small receive ring for an Ethernet MAC. It keeps a fixed ring of four descriptors internally. Each one has a link pointer, a command/status word and a buffer pointer, and each owns a 1536-byte slice of an internal buffer memory. Received frames arrive as a byte stream with a last-byte marker and an error flag that is sampled with the last byte. The engine writes each accepted frame into the buffer of the current slot. It then completes the status word, with the byte count, the packet-OK flag and the too-long flag, and sets the ownership bit to hand the slot to the host. Finally it moves on to the next slot in the ring.

The host reads descriptor fields and buffer bytes through plain read ports. It returns a slot by writing the buffer size into that slot's command/status word, which leaves the ownership bit clear. Three single-cycle command inputs control the receiver: enable, disable and clear. When the engine reaches a slot that the host still owns, it stops and discards incoming frames. It accepts frames again only after the slot has been returned and a later enable command has arrived.

Top module: `rxring_engine`

## Requirements
- R1: After reset, and after a clear command, every command/status word reads 0x0000_0600 (1536, ownership bit 31 clear), and irq_pulse is low.
- R2: Descriptors sit 16 bytes apart, starting at address 0. hst_rfield 0 returns the link, which is the address of descriptor (i+1) mod 4. Field 1 returns the command/status word, field 2 returns the buffer pointer i*1536, and field 3 returns zero.
- R3: A completed slot's status word has bit 31 set. Bits [11:0] hold the stored byte count, which includes the 4 CRC bytes. Bits 30 (more fragments) and 29 are always zero.
- R4: Bit 27 (packet OK) is set exactly when in_err is low on the last byte and the frame was not too long.
- R5: A frame longer than 1536 bytes keeps only its first 1536 bytes. Its count reads 1536, bit 22 (too long) is set and bit 27 is clear. A frame of exactly 1536 bytes is not too long.
- R6: Byte k of a frame stored in slot s can be read at buf_raddr = s*1536 + k.
- R7: Frames fill slots 0, 1, 2, 3 in order and then wrap back to slot 0.
- R8: irq_pulse is high for exactly one cycle per completed descriptor, in the same cycle in which the completed status first becomes readable.
- R9: Frames that begin while the receiver is disabled are discarded whole: no status changes and no pulse. Enable and disable take effect at frame boundaries.
- R10: When the current slot has bit 31 set, the engine stalls and discards whole frames. Returning the slot alone does not resume it. A later enable command, at least one cycle after the return, resumes reception into that slot.
- R11: A host write replaces a slot's command/status word. A write in the same cycle as a completion into a different slot takes effect alongside it; for the same slot, the completion wins.
- R12: The clear command disables the receiver, returns every descriptor to the host-free state and points the engine at slot 0. Priority is clear, then disable, then enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_rx_on | input | 1 | Enable pulse; also resumes a stalled engine |
| cmd_rx_off | input | 1 | Disable pulse |
| cmd_rx_clr | input | 1 | Receiver clear pulse |
| in_valid | input | 1 | Received byte valid |
| in_byte | input | 8 | Received byte |
| in_last | input | 1 | Last byte of the frame |
| in_err | input | 1 | Frame error flag, sampled with the last byte |
| hst_wr | input | 1 | Host write strobe for a command/status word |
| hst_wslot | input | 2 | Slot being written |
| hst_wdata | input | 32 | Command/status value written |
| hst_rslot | input | 2 | Slot being read |
| hst_rfield | input | 2 | Field select: 0 link, 1 command/status, 2 buffer pointer |
| hst_rdata | output | 32 | Selected descriptor field |
| buf_raddr | input | 13 | Buffer memory byte address |
| buf_rdata | output | 8 | Buffer memory byte |
| irq_pulse | output | 1 | One-cycle pulse per completed descriptor |

## Verification
Two functions can fall in the same cycle: the host returning one slot, and the engine completing a frame into another. The bench provokes this by raising the host write on the same cycle as the frame's last byte. It then judges both slots' status words against a bench-side ring model. Slot ordering, stall and resume, truncation and the error flag are swept over frame lengths around the 1536-byte boundary, and every slot's word is compared after each frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int OWN_BIT  = 31;
  localparam int MORE_BIT = 30;
  localparam int OK_BIT   = 27;
  localparam int LONG_BIT = 22;
  localparam int LEN_W    = 12;

  typedef logic [31:0] sts_word_t;

  function automatic sts_word_t mk_status(input logic ok, input logic lng,
                                          input logic [LEN_W-1:0] len);
    sts_word_t w;
    w           = '0;
    w[OWN_BIT]  = 1'b1;
    w[MORE_BIT] = 1'b0;
    w[OK_BIT]   = ok;
    w[LONG_BIT] = lng;
    w[LEN_W-1:0] = len;
    return w;
  endfunction
endpackage

// File: rtl/rxr_buf_mem.sv
module rxr_buf_mem #(
  parameter int TOTAL_BYTES = 6144,
  localparam int ADDR_W = $clog2(TOTAL_BYTES),
  localparam int WORDS  = TOTAL_BYTES / 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr[ADDR_W-1:2]][{waddr[1:0], 3'b000} +: 8] <= wdata;
  end

  always_comb rdata = mem[raddr[ADDR_W-1:2]][{raddr[1:0], 3'b000} +: 8];
endmodule

// File: rtl/rxr_desc_table.sv
module rxr_desc_table
  import rxr_pkg::*;
#(
  parameter int N_SLOTS   = 4,
  parameter int BUF_BYTES = 1536,
  localparam int SLOT_W   = $clog2(N_SLOTS),
  localparam int DESC_SH  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               eng_done,
  input  logic [SLOT_W-1:0]  eng_slot,
  input  sts_word_t          eng_word,
  input  logic               hst_wr,
  input  logic [SLOT_W-1:0]  hst_slot,
  input  sts_word_t          hst_wdata,
  input  logic [SLOT_W-1:0]  rd_slot,
  input  logic [1:0]         rd_field,
  output logic [31:0]        rd_data,
  output logic [N_SLOTS-1:0] own_vec
);
  localparam sts_word_t FREE_WORD = sts_word_t'(BUF_BYTES);

  sts_word_t sts_arr [N_SLOTS];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    sts_word_t d_q, d_d;

    always_comb begin
      d_d = d_q;
      if (hst_wr && hst_slot == SLOT_W'(i)) d_d = hst_wdata;
      if (eng_done && eng_slot == SLOT_W'(i)) d_d = eng_word;
      if (clr) d_d = FREE_WORD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= FREE_WORD;
      else        d_q <= d_d;
    end

    assign sts_arr[i] = d_q;
    assign own_vec[i] = d_q[OWN_BIT];

    // R3: a completion hands the slot to the host
    a_r3_own_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !clr && eng_slot == SLOT_W'(i)) |=> own_vec[i]);
  end

  logic [SLOT_W-1:0] nxt_slot;
  always_comb begin
    nxt_slot = (rd_slot == SLOT_W'(N_SLOTS - 1)) ? '0 : rd_slot + SLOT_W'(1);
    case (rd_field)
      2'd0:    rd_data = 32'(nxt_slot) << DESC_SH;
      2'd1:    rd_data = sts_arr[rd_slot];
      2'd2:    rd_data = 32'(rd_slot) * 32'(BUF_BYTES);
      default: rd_data = '0;
    endcase
  end

  // R12: clear frees every slot
  a_r12_clr_frees: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (own_vec == '0));
endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
  import rxr_pkg::*;
#(
  parameter int N_SLOTS   = 4,
  parameter int BUF_BYTES = 1536,
  localparam int SLOT_W   = $clog2(N_SLOTS),
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W   = $clog2(N_SLOTS * BUF_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_on,
  input  logic               cmd_off,
  input  logic               cmd_clr,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic               in_err,
  input  logic [N_SLOTS-1:0] own_vec,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic               done,
  output logic [SLOT_W-1:0]  done_slot,
  output sts_word_t          done_word,
  output logic               irq
);
  logic              en_q, en_d, stall_q, stall_d, busy_q, busy_d;
  logic              drop_q, drop_d, long_q, long_d, irq_q, irq_d;
  logic [SLOT_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_fin;
  logic              room, start, can_go, take, long_now;

  always_comb begin
    room     = (cnt_q < CNT_W'(BUF_BYTES));
    start    = in_valid && !busy_q && !drop_q;
    can_go   = en_q && !stall_q && !own_vec[cur_q];
    take     = in_valid && (busy_q || (start && can_go)) && !cmd_clr;
    wr_en    = take && room;
    long_now = long_q || (take && !room);
    done     = take && in_last;
    cnt_fin  = cnt_q + (wr_en ? CNT_W'(1) : CNT_W'(0));
    done_word = mk_status(!in_err && !long_now, long_now, LEN_W'(cnt_fin));
    done_slot = cur_q;
    wr_addr  = ADDR_W'(cur_q) * ADDR_W'(BUF_BYTES) + ADDR_W'(cnt_q);

    en_d    = en_q;
    stall_d = stall_q;
    busy_d  = busy_q;
    drop_d  = drop_q;
    long_d  = long_q;
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    irq_d   = done;

    if (cmd_on) en_d = 1'b1;
    if (cmd_off) en_d = 1'b0;
    if (stall_q && cmd_on && !own_vec[cur_q]) stall_d = 1'b0;
    if (en_q && !busy_q && own_vec[cur_q]) stall_d = 1'b1;

    if (take) begin
      busy_d = !in_last;
      long_d = in_last ? 1'b0 : long_now;
      if (wr_en) cnt_d = cnt_q + CNT_W'(1);
      if (in_last) begin
        cnt_d = '0;
        cur_d = (cur_q == SLOT_W'(N_SLOTS - 1)) ? '0 : cur_q + SLOT_W'(1);
      end
    end
    if (start && !take && !in_last) drop_d = 1'b1;
    if (drop_q && in_valid && in_last) drop_d = 1'b0;

    if (cmd_clr) begin
      en_d = 1'b0; stall_d = 1'b0; busy_d = 1'b0; drop_d = 1'b0;
      long_d = 1'b0; cur_d = '0; cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; stall_q <= 1'b0; busy_q <= 1'b0; drop_q <= 1'b0;
      long_q <= 1'b0; cur_q <= '0; cnt_q <= '0; irq_q <= 1'b0;
    end else begin
      en_q <= en_d; stall_q <= stall_d; busy_q <= busy_d; drop_q <= drop_d;
      long_q <= long_d; cur_q <= cur_d; cnt_q <= cnt_d; irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R5: the fill count never passes the buffer size
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUF_BYTES));
  // R10: nothing is written while stalled
  a_r10_no_write_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> !wr_en);
  // R10: a frame never starts in a host-owned slot
  a_r10_no_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy_q) |-> !own_vec[cur_q]);
  // R9: a disabled receiver starts no frame
  a_r9_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !busy_q) |-> !wr_en);
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
  import rxr_pkg::*;
#(
  parameter int N_SLOTS   = 4,
  parameter int BUF_BYTES = 1536,
  localparam int SLOT_W   = $clog2(N_SLOTS),
  localparam int ADDR_W   = $clog2(N_SLOTS * BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rx_on,
  input  logic              cmd_rx_off,
  input  logic              cmd_rx_clr,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  input  logic              in_err,
  input  logic              hst_wr,
  input  logic [SLOT_W-1:0] hst_wslot,
  input  logic [31:0]       hst_wdata,
  input  logic [SLOT_W-1:0] hst_rslot,
  input  logic [1:0]        hst_rfield,
  output logic [31:0]       hst_rdata,
  input  logic [ADDR_W-1:0] buf_raddr,
  output logic [7:0]        buf_rdata,
  output logic              irq_pulse
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_i;
  logic [N_SLOTS-1:0] own_vec;
  logic               wr_en, done;
  logic [ADDR_W-1:0]  wr_addr;
  logic [SLOT_W-1:0]  done_slot;
  sts_word_t          done_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  rxr_frame_ctl #(.N_SLOTS(N_SLOTS), .BUF_BYTES(BUF_BYTES)) ctl_i (
    .clk(clk), .rst_n(rst_n_i), .cmd_on(cmd_rx_on), .cmd_off(cmd_rx_off),
    .cmd_clr(cmd_rx_clr), .in_valid(in_valid), .in_last(in_last),
    .in_err(in_err), .own_vec(own_vec), .wr_en(wr_en), .wr_addr(wr_addr),
    .done(done), .done_slot(done_slot), .done_word(done_word), .irq(irq_pulse)
  );

  rxr_desc_table #(.N_SLOTS(N_SLOTS), .BUF_BYTES(BUF_BYTES)) desc_i (
    .clk(clk), .rst_n(rst_n_i), .clr(cmd_rx_clr), .eng_done(done),
    .eng_slot(done_slot), .eng_word(done_word), .hst_wr(hst_wr),
    .hst_slot(hst_wslot), .hst_wdata(hst_wdata), .rd_slot(hst_rslot),
    .rd_field(hst_rfield), .rd_data(hst_rdata), .own_vec(own_vec)
  );

  rxr_buf_mem #(.TOTAL_BYTES(N_SLOTS * BUF_BYTES)) mem_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_byte),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );
endmodule

// File: tb/rxring_engine_tb_top.sv
module rxring_engine_tb_top;
  localparam int N   = 4;
  localparam int BUF = 1536;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_rx_on = 0, cmd_rx_off = 0, cmd_rx_clr = 0;
  logic in_valid = 0, in_last = 0, in_err = 0;
  logic [7:0] in_byte = '0;
  logic hst_wr = 0;
  logic [1:0] hst_wslot = '0, hst_rslot = '0, hst_rfield = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic [12:0] buf_raddr = '0;
  logic [7:0] buf_rdata;
  logic irq_pulse;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic        m_en = 0, m_stall = 0;
  int          m_cur = 0;
  logic [31:0] m_desc [N];

  always #10 clk = ~clk;

  rxring_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_rx_on(cmd_rx_on), .cmd_rx_off(cmd_rx_off),
    .cmd_rx_clr(cmd_rx_clr), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_err(in_err), .hst_wr(hst_wr), .hst_wslot(hst_wslot),
    .hst_wdata(hst_wdata), .hst_rslot(hst_rslot), .hst_rfield(hst_rfield),
    .hst_rdata(hst_rdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_field(input int slot, input int fld, output logic [31:0] v);
    hst_rslot = 2'(slot); hst_rfield = 2'(fld); #1; v = hst_rdata;
  endtask

  task automatic rd_buf(input int addr, output logic [7:0] v);
    buf_raddr = 13'(addr); #1; v = buf_rdata;
  endtask

  function automatic logic [7:0] pat(input int base, input int k);
    return 8'((base + k * 7) & 255);
  endfunction

  function automatic logic [31:0] exp_sts(input int len, input bit err);
    int  cnt = (len > BUF) ? BUF : len;
    bit  lng = (len > BUF);
    logic [31:0] w = 32'h8000_0000 | 32'(cnt);
    if (lng) w[22] = 1'b1;
    if (!err && !lng) w[27] = 1'b1;
    return w;
  endfunction

  task automatic settle();
    if (m_en && m_desc[m_cur][31]) m_stall = 1'b1;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int s = 0; s < N; s++) begin
      rd_field(s, 1, v);
      chk(tag, v, m_desc[s]);
    end
  endtask

  task automatic pulse_cmd(input bit on, input bit off, input bit clr);
    cmd_rx_on = on; cmd_rx_off = off; cmd_rx_clr = clr;
    @(negedge clk);
    cmd_rx_on = 0; cmd_rx_off = 0; cmd_rx_clr = 0;
    if (clr) begin
      m_en = 0; m_stall = 0; m_cur = 0;
      for (int s = 0; s < N; s++) m_desc[s] = 32'(BUF);
    end else if (off) m_en = 0;
    else if (on) begin
      if (m_stall && !m_desc[m_cur][31]) m_stall = 0;
      m_en = 1;
    end
    @(negedge clk);
    settle();
  endtask

  task automatic host_return(input int slot);
    hst_wr = 1; hst_wslot = 2'(slot); hst_wdata = 32'(BUF);
    @(negedge clk);
    hst_wr = 0;
    m_desc[slot] = 32'(BUF);
    @(negedge clk);
  endtask

  // ret >= 0: host returns that slot in the cycle of the last byte
  task automatic send_frame(input int len, input bit err, input int base,
                            input int ret, input string tag);
    int  slot = m_cur;
    bit  acc  = m_en && !m_stall && !m_desc[m_cur][31];
    int  irqs = 0;
    int  kept = (len > BUF) ? BUF : len;
    logic [7:0] b;
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_byte = pat(base, i);
      in_last = (i == len - 1); in_err = (i == len - 1) && err;
      if (i == len - 1 && ret >= 0) begin
        hst_wr = 1; hst_wslot = 2'(ret); hst_wdata = 32'(BUF);
      end
      @(negedge clk);
      irqs += int'(irq_pulse);
    end
    in_valid = 0; in_last = 0; in_err = 0; hst_wr = 0;
    @(negedge clk);
    irqs += int'(irq_pulse);
    if (ret >= 0) m_desc[ret] = 32'(BUF);
    if (acc) begin
      m_desc[slot] = exp_sts(len, err);
      m_cur = (m_cur + 1) % N;
    end
    settle();
    @(negedge clk);
    chk({tag, " R8 pulse count"}, 32'(irqs), acc ? 32'd1 : 32'd0);
    check_all({tag, " status"});
    if (acc) begin
      rd_buf(slot * BUF, b);            chk({tag, " R6 first byte"}, 32'(b), 32'(pat(base, 0)));
      rd_buf(slot * BUF + kept - 1, b); chk({tag, " R6 last kept byte"}, 32'(b), 32'(pat(base, kept - 1)));
      rd_buf(slot * BUF + kept / 2, b); chk({tag, " R6 middle byte"}, 32'(b), 32'(pat(base, kept / 2)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int s = 0; s < N; s++) m_desc[s] = 32'(BUF);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1, R2: reset contents and fixed descriptor fields
    chk("R1 irq after reset", 32'(irq_pulse), 32'd0);
    for (int s = 0; s < N; s++) begin
      rd_field(s, 1, v); chk("R1 free word after reset", v, 32'h0000_0600);
      rd_field(s, 0, v); chk("R2 link field", v, 32'(((s + 1) % N) * 16));
      rd_field(s, 2, v); chk("R2 buffer pointer", v, 32'(s * BUF));
      rd_field(s, 3, v); chk("R2 spare field", v, 32'd0);
    end

    // R9: disabled receiver discards
    send_frame(40, 0, 3, -1, "R9 disabled");
    pulse_cmd(1, 0, 0);
    // R3 R4 R5 R7: sweep lengths across the ring
    send_frame(60, 0, 11, -1, "R3 R7 slot0");
    host_return(0);
    send_frame(1, 1, 20, -1, "R4 error flag slot1");
    send_frame(BUF, 0, 33, -1, "R5 exact size slot2");
    send_frame(BUF + 1, 0, 47, -1, "R5 one over slot3");
    send_frame(64, 1, 5, -1, "R7 wrap slot0");
    // R10: next slot owned, engine stalls
    send_frame(70, 0, 9, -1, "R10 stalled drop");
    host_return(1);
    send_frame(70, 0, 9, -1, "R10 returned without enable");
    pulse_cmd(1, 0, 0);
    send_frame(2000, 0, 61, -1, "R5 R10 resumed truncated");
    host_return(2);
    host_return(3);
    pulse_cmd(1, 0, 0);
    // R11: return slot0 in the same cycle as completion into slot2
    send_frame(90, 0, 77, 0, "R11 concurrent return");
    // R9: disable and re-enable at frame boundaries
    pulse_cmd(0, 1, 0);
    send_frame(30, 0, 2, -1, "R9 after disable");
    pulse_cmd(1, 0, 0);
    send_frame(2, 0, 13, -1, "R9 after re-enable");
    // R12: clear, with enable in the same cycle losing
    pulse_cmd(1, 0, 1);
    check_all("R12 R1 after clear");
    send_frame(50, 0, 8, -1, "R12 clear beats enable");
    pulse_cmd(1, 1, 0);
    send_frame(50, 0, 8, -1, "R12 disable beats enable");
    pulse_cmd(1, 0, 0);
    send_frame(100, 0, 99, -1, "R12 slot0 after clear");
    send_frame(3, 0, 1, -1, "R7 slot1 after clear");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule